// File: doc/BRIEF.md
# Receive Buffer Ring Fetcher

This block keeps the receive side of a network controller supplied with buffers. Software places a circular table of buffer descriptors in memory. Each entry holds four halfword fields: the buffer address split into low and high halves, then the buffer size in words, also split into low and high halves. When it gets a request, the block reads the entry at its read pointer with a simple halfword read master. It loads the fields into the current-buffer registers and moves the read pointer forward, wrapping back to the start pointer when it reaches the end pointer. If the pointer then catches up with the software write pointer, the block raises a ring-exhausted flag.

A fetch has three possible triggers: an explicit command from the command unit, the receiver reporting that the current buffer has too little room left, or software clearing the exhausted flag while it is set. The entry address is formed by placing the upper-address register above the 16-bit read pointer. In wide bus mode each field sits in a 32-bit slot, so fields are 4 bytes apart and entries are 16 bytes. In narrow mode fields are 2 bytes apart and entries are 8 bytes. Only one memory read is in flight at a time. A busy flag makes the block ignore new requests until the fetch completes.

Top module: `rx_ring_fetch`

## Requirements
- R1: After reset, the start, end, read and write pointers, the upper-address register and both current-buffer registers are zero; busy, done, the command-pending bit, the exhausted flag and mem_req are all low.
- R2: While idle, a fetch begins (busy is high in the next cycle) on cmd_req, on rx_low_req, or on exh_clr while exhausted is set. exh_clr while exhausted is clear starts nothing.
- R3: While busy, cmd_req, rx_low_req and exh_clr start no further fetch. mem_req is a one-cycle pulse, and the next pulse only comes after mem_valid has returned the previous read.
- R4: Field k (k = 0, 1, 2, 3, read in that order) is read at {upper, read pointer} + 2k when cfg_wide is 0, and at {upper, read pointer} + 4k when cfg_wide is 1.
- R5: Field 0 loads buf_addr[15:0], field 1 loads buf_addr[31:16], field 2 loads buf_words[15:0] and field 3 loads buf_words[31:16].
- R6: When a fetch completes, the read pointer becomes (read pointer + 8) mod 2^16 in narrow mode, or + 16 in wide mode. If that value equals the end pointer, the start pointer is loaded instead.
- R7: When a fetch completes and the new read pointer equals the write pointer, exhausted is set. exh_clr clears it.
- R8: done pulses for one cycle in the cycle busy falls. cmd_pend is set only by an accepted cmd_req and is cleared when the fetch completes.
- R9: A write with reg_sel 0, 1, 2 or 3 sets the start, end, read or write pointer respectively, with bit 0 forced to 0. reg_sel 4 writes all 16 bits of the upper-address register. reg_rdata returns the selected register. reg_sel 5 to 7 read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wide | input | 1 | 1 selects 32-bit field slots |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Selected register value |
| cmd_req | input | 1 | Read-resource command |
| rx_low_req | input | 1 | Receiver asks for a new buffer |
| exh_clr | input | 1 | Clear exhausted flag (may trigger a fetch) |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_pend | output | 1 | Read-resource command bit |
| exhausted | output | 1 | Ring exhausted flag |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | 32 | Memory byte address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data (low half of the slot in wide mode) |
| buf_addr | output | 32 | Current buffer address |
| buf_words | output | 32 | Current buffer word count |

## Verification
The assertions assume that mem_valid arrives only for a read that is outstanding, never in the same cycle as the request that started it. They also assume that cfg_wide and the pointer registers stay unchanged while busy. The bench's memory responder captures each mem_req and answers exactly once after a fixed latency. All pointer writes and mode changes are issued while the block is idle. exh_clr is never issued in a cycle where a fetch can complete, so the set-versus-clear priority is never exercised.

// File: rtl/rx_ring_fetch.sv
module rx_ring_fetch #(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wide,
  input  logic             reg_wr,
  input  logic [2:0]       reg_sel,
  input  logic [W-1:0]     reg_wdata,
  output logic [W-1:0]     reg_rdata,
  input  logic             cmd_req,
  input  logic             rx_low_req,
  input  logic             exh_clr,
  output logic             busy,
  output logic             done,
  output logic             cmd_pend,
  output logic             exhausted,
  output logic             mem_req,
  output logic [2*W-1:0]   mem_addr,
  input  logic             mem_valid,
  input  logic [W-1:0]     mem_rdata,
  output logic [2*W-1:0]   buf_addr,
  output logic [2*W-1:0]   buf_words
);
  localparam int AW = 2 * W;

  logic [W-1:0] start_p, end_p, rd_p, wr_p, upper;
  logic [1:0]   idx;
  logic         outst;

  wire          take  = busy & outst & mem_valid;
  wire          last  = take & (idx == 2'd3);
  wire          trig  = ~busy & (cmd_req | rx_low_req | (exh_clr & exhausted));
  wire [W-1:0]  step  = cfg_wide ? W'(16) : W'(8);
  wire [W-1:0]  nxt   = rd_p + step;
  wire [W-1:0]  wrapd = (nxt == end_p) ? start_p : nxt;

  assign mem_req  = busy & ~outst;
  assign mem_addr = {upper, rd_p} + (AW'(idx) << (cfg_wide ? 2 : 1));

  always_comb begin
    case (reg_sel)
      3'd0:    reg_rdata = start_p;
      3'd1:    reg_rdata = end_p;
      3'd2:    reg_rdata = rd_p;
      3'd3:    reg_rdata = wr_p;
      3'd4:    reg_rdata = upper;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_p <= '0;
      end_p   <= '0;
      rd_p    <= '0;
      wr_p    <= '0;
      upper   <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_sel)
          3'd0:    start_p <= reg_wdata & ~W'(1);
          3'd1:    end_p   <= reg_wdata & ~W'(1);
          3'd2:    rd_p    <= reg_wdata & ~W'(1);
          3'd3:    wr_p    <= reg_wdata & ~W'(1);
          3'd4:    upper   <= reg_wdata;
          default: ;
        endcase
      end
      if (last) rd_p <= wrapd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      outst     <= 1'b0;
      idx       <= '0;
      done      <= 1'b0;
      cmd_pend  <= 1'b0;
      exhausted <= 1'b0;
      buf_addr  <= '0;
      buf_words <= '0;
    end else begin
      done <= last;
      if (exh_clr) exhausted <= 1'b0;
      if (mem_req) outst <= 1'b1;
      if (take) begin
        outst <= 1'b0;
        idx   <= idx + 2'd1;
        case (idx)
          2'd0: buf_addr[W-1:0]   <= mem_rdata;
          2'd1: buf_addr[AW-1:W]  <= mem_rdata;
          2'd2: buf_words[W-1:0]  <= mem_rdata;
          2'd3: buf_words[AW-1:W] <= mem_rdata;
        endcase
      end
      if (last) begin
        busy     <= 1'b0;
        cmd_pend <= 1'b0;
        if (wrapd == wr_p) exhausted <= 1'b1;
      end
      if (trig) begin
        busy  <= 1'b1;
        outst <= 1'b0;
        idx   <= '0;
        if (cmd_req) cmd_pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_ring_fetch_chk.sv
module rx_ring_fetch_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic cmd_pend,
  input logic exhausted,
  input logic mem_req,
  input logic cmd_req,
  input logic rx_low_req
);
  // R3
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R8
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_pend);
  // R7
  exh_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exhausted) |-> done);
  // R2
  idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_req && !rx_low_req && !exhausted) |=> !busy);
endmodule

bind rx_ring_fetch rx_ring_fetch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .cmd_pend(cmd_pend),
  .exhausted(exhausted), .mem_req(mem_req), .cmd_req(cmd_req),
  .rx_low_req(rx_low_req)
);

// File: tb/test_rx_ring_fetch.sv
module test_rx_ring_fetch;
  localparam int LAT = 3;

  logic clk = 0, rst_n = 0;
  logic cfg_wide = 0, reg_wr = 0;
  logic [2:0] reg_sel = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic cmd_req = 0, rx_low_req = 0, exh_clr = 0;
  logic busy, done, cmd_pend, exhausted, mem_req, mem_valid = 0;
  logic [31:0] mem_addr, buf_addr, buf_words;
  logic [15:0] mem_rdata = 0;

  int vecs = 0, errs = 0;

  rx_ring_fetch i_rx_ring_fetch (.*);

  always #4 clk = ~clk;

  function automatic logic [15:0] memf(input logic [31:0] a);
    return a[15:0] ^ a[31:16] ^ 16'h5A3C;
  endfunction

  // memory responder
  bit pend = 0; int cnt = 0; logic [31:0] cap;
  always @(negedge clk) begin
    mem_valid = 0;
    if (pend) begin
      cnt--;
      if (cnt == 0) begin mem_valid = 1; mem_rdata = memf(cap); pend = 0; end
    end else if (rst_n && mem_req) begin
      pend = 1; cap = mem_addr; cnt = LAT;
    end
  end

  // behavioural reference model
  logic [15:0] m_reg[5];
  logic [31:0] m_ba, m_bw;
  bit m_busy, m_out, m_done, m_cp, m_exh;
  int m_idx;
  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_reg[i]) m_reg[i] = 0;
      m_ba = 0; m_bw = 0; m_busy = 0; m_out = 0; m_done = 0; m_cp = 0; m_exh = 0; m_idx = 0;
    end else begin
      automatic logic [15:0] ord = m_reg[2];
      automatic bit trig = !m_busy && (cmd_req || rx_low_req || (exh_clr && m_exh));
      automatic bit take = m_busy && m_out && mem_valid;
      automatic bit last = take && m_idx == 3;
      m_done = last;
      if (reg_wr && reg_sel < 4) m_reg[reg_sel] = reg_wdata & 16'hFFFE;
      if (reg_wr && reg_sel == 4) m_reg[4] = reg_wdata;
      if (exh_clr) m_exh = 0;
      if (take) begin
        case (m_idx)
          0: m_ba[15:0] = mem_rdata;
          1: m_ba[31:16] = mem_rdata;
          2: m_bw[15:0] = mem_rdata;
          default: m_bw[31:16] = mem_rdata;
        endcase
        m_out = 0; m_idx = (m_idx + 1) % 4;
        if (last) begin
          automatic logic [15:0] nr = ord + (cfg_wide ? 16 : 8);
          if (nr == m_reg[1]) nr = m_reg[0];
          m_reg[2] = nr;
          if (nr == m_reg[3]) m_exh = 1;
          m_busy = 0; m_cp = 0;
        end
      end else if (m_busy && !m_out) m_out = 1;
      if (trig) begin
        m_busy = 1; m_out = 0; m_idx = 0;
        if (cmd_req) m_cp = 1;
      end
    end
  end

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      cmp("R2 busy", busy, m_busy);
      cmp("R3 mem_req", mem_req, m_busy && !m_out);
      if (m_busy && !m_out)
        cmp("R4 mem_addr", mem_addr, {m_reg[4], m_reg[2]} + m_idx * (cfg_wide ? 4 : 2));
      cmp("R5 buf_addr", buf_addr, m_ba);
      cmp("R5 buf_words", buf_words, m_bw);
      cmp("R7 exhausted", exhausted, m_exh);
      cmp("R8 done", done, m_done);
      cmp("R8 cmd_pend", cmd_pend, m_cp);
      cmp("R9 reg_rdata", reg_rdata, reg_sel < 5 ? 32'(m_reg[reg_sel]) : 32'h0);
    end
  end

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input string tag, input logic [2:0] s, input logic [15:0] exp);
    @(negedge clk); reg_sel = s; #1;
    cmp(tag, reg_rdata, exp);
  endtask

  task automatic finish_fetch();
    do @(negedge clk); while (busy);
  endtask

  task automatic go(input int which);
    @(negedge clk);
    if (which == 0) cmd_req = 1; else if (which == 1) rx_low_req = 1; else exh_clr = 1;
    @(negedge clk); cmd_req = 0; rx_low_req = 0; exh_clr = 0;
  endtask

  task automatic run();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    cmp("R1 busy", busy, 0); cmp("R1 exhausted", exhausted, 0);
    cmp("R1 buf_addr", buf_addr, 0); cmp("R1 buf_words", buf_words, 0);
    cmp("R1 mem_req", mem_req, 0); cmp("R1 cmd_pend", cmd_pend, 0);
    for (int s = 0; s < 5; s++) rd("R1 reg", 3'(s), 16'h0);
    // R9 register access
    wr(0, 16'h1001); wr(1, 16'h1041); wr(2, 16'h1000); wr(3, 16'h1031); wr(4, 16'hABCD);
    wr(5, 16'hFFFF);
    rd("R9 start", 0, 16'h1000); rd("R9 end", 1, 16'h1040); rd("R9 wr", 3, 16'h1030);
    rd("R9 upper", 4, 16'hABCD); rd("R9 sel5", 5, 16'h0);
    // narrow fetch by command
    go(0);
    cmp("R8 cmd_pend set", cmd_pend, 1);
    finish_fetch();
    rd("R6 narrow step", 2, 16'h1008);
    cmp("R5 addr", buf_addr, {memf(32'hABCD1002), memf(32'hABCD1000)});
    cmp("R5 words", buf_words, {memf(32'hABCD1006), memf(32'hABCD1004)});
    cmp("R8 cmd_pend clr", cmd_pend, 0);
    // wide fetch by receiver, command during busy ignored (R3)
    cfg_wide = 1;
    go(1);
    cmd_req = 1; @(negedge clk); cmd_req = 0;
    cmp("R3 cmd ignored", cmd_pend, 0);
    finish_fetch();
    rd("R6 wide step", 2, 16'h1018);
    cmp("R4 wide field2", buf_words[15:0], memf(32'hABCD1010));
    // exh_clr while not exhausted: nothing (R2)
    go(2); @(negedge clk);
    cmp("R2 clr idle", busy, 0);
    // narrow wrap to start
    cfg_wide = 0;
    wr(3, 16'h1008); wr(2, 16'h1038);
    go(0); finish_fetch();
    rd("R6 wrap", 2, 16'h1000);
    cmp("R7 not exh", exhausted, 0);
    go(1); finish_fetch();
    rd("R6 step to wr", 2, 16'h1008);
    cmp("R7 exhausted", exhausted, 1);
    // clearing exhausted restarts a fetch (R2)
    go(2);
    cmp("R2 clr fetch", busy, 1);
    finish_fetch();
    rd("R6 after clr", 2, 16'h1010);
    cmp("R7 cleared", exhausted, 0);
    // wide wrap
    cfg_wide = 1; wr(2, 16'h1030);
    go(0); finish_fetch();
    rd("R6 wide wrap", 2, 16'h1000);
    // upper register wraps into the address high half (R4)
    wr(4, 16'h0001); wr(2, 16'hFFF0); wr(1, 16'h0000); wr(0, 16'h2000);
    go(1); finish_fetch();
    rd("R6 mod wrap", 2, 16'h2000);
    cmp("R4 high field", buf_words[31:16], memf(32'h0001FFFC));
    repeat (4) @(negedge clk);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule